// File: doc/BRIEF.md
# Accumulator Push-Down Stack Controller

This block manages an accumulator stack kept in a fixed 64-word window of main memory, on behalf of a processor core with four priority levels. It holds four mode flags for each level (floating, stacking, pending result, overflow) and one stack pointer that all levels share. For each instruction the core presents the function number, the modifier flag, a flag saying the address field is zero, the level and the accumulator and exponent registers. The block answers with memory requests that push or pop stack words, a signal that the instruction needs extra time, and the updated flags. It also gives a readback word with the flags of the current level and the pointer.

Pushes are lazy. An instruction that leaves a fresh result in the accumulator only sets the pending flag. The result goes to memory only when a later load would overwrite it. In floating mode each stack entry is two words, an exponent and a mantissa, so the pointer moves by two for each entry. The instruction is held until every stack word transfer has been acknowledged on a valid/ready memory port. It completes in the cycle of the last acknowledge.

Top module: `acc_stack_ctrl`

## Requirements
- R1: After reset every level's four flags are 0 and the pointer reads 127.
- R2: `rdback_o` holds floating in bit 17, stacking in bit 16, pending in bit 15, overflow in bit 14, zeros in bits 13..7 and the 7-bit pointer in bits 6..0. Function 15 with `sys_op_i`=2 loads `acc_i[17:14]` into the current level's flags in that same order.
- R3: Each level's flags are kept separately. A flag write on one level leaves the other levels unchanged.
- R4: With stacking set, functions 1, 4, 6, 12, 13 and 14 with `blk_xfer_i`=0 (shift) set pending. Functions 5, 7 and 9 clear it. All other functions leave it as it is. With stacking clear, pending never changes.
- R5: Function 4 with stacking and pending set pushes `acc_i` as a write to address pointer+1 and leaves the pointer at that address. `extra_cycle_o` is high while such a load is presented.
- R6: With stacking set, an unmodified instruction with a zero address field and function 1, 2, 4, 6, 12 or 13 reads the word at the pointer, returns it on `pop_mant_o` and decrements the pointer. A modified instruction makes no stack request.
- R7: In floating mode a push writes `exp_i` to pointer+1 and then `acc_i` to pointer+2. A pop reads the mantissa at the pointer into `pop_mant_o` and then the exponent at pointer-1 into `pop_exp_o`. Each direction moves the pointer by 2.
- R8: The pointer wraps from 127 to 64 on a push and from 64 to 127 on a pop, so all stack addresses fall in 64..127.
- R9: Function 15 with `sys_op_i`=1 sets the pointer to 127.
- R10: A stack request stays asserted and stable until it is acknowledged. `ins_ready_o` rises only with `ins_valid_i`, and only in the cycle of the last acknowledge when there are transfers. With no `ins_valid_i` there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Instruction presented, held until ready |
| ins_ready_o | output | 1 | Instruction completes this cycle |
| func_i | input | 4 | Function number 0..15 |
| modified_i | input | 1 | Instruction is index-modified |
| addr_zero_i | input | 1 | Address field is zero |
| blk_xfer_i | input | 1 | Function 14 is a block transfer, not a shift |
| sys_op_i | input | 2 | Function 15 sub-op: 0 other, 1 pointer reset, 2 set flags |
| level_i | input | 2 | Current priority level |
| acc_i | input | 18 | Accumulator (mantissa) |
| exp_i | input | 18 | Exponent register |
| mem_req_valid_o | output | 1 | Stack word request |
| mem_req_ready_i | input | 1 | Request acknowledged, read data valid |
| mem_we_o | output | 1 | 1 push write, 0 pop read |
| mem_addr_o | output | 7 | Stack word address |
| mem_wdata_o | output | 18 | Push data |
| mem_rdata_i | input | 18 | Pop data |
| pop_mant_o | output | 18 | Last popped operand or mantissa |
| pop_exp_o | output | 18 | Last popped exponent |
| extra_cycle_o | output | 1 | Load must push first |
| mode_o | output | 4 | Current level flags {floating, stacking, pending, overflow} |
| rdback_o | output | 18 | Flags and pointer readback word |

## Verification
On every cycle the assertions check that a pending request holds until it is acknowledged, that no request appears without an instruction, and that after a push or pop the pointer sits at the expected place relative to the address just used. They also check that pending is clear after a consuming function and that the flag bank stays unchanged between writes. Other behaviour only shows up in the bench's scenarios: the exact sequence of lazy pushes, the order of exponent and mantissa in floating entries, the wrap at both ends of the window and the independence of the levels. The bench checks these against a reference model, under random memory back-pressure.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef struct packed {
    logic flp;
    logic stk;
    logic par;
    logic ovf;
  } mode_t;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_PUSH = 2'd1,
    PH_POP  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    OP_PLAIN     = 2'd0,
    OP_PTR_RST   = 2'd1,
    OP_SET_MODES = 2'd2
  } sysop_e;
endpackage

// File: rtl/acs_par_rule.sv
module acs_par_rule (
  input  logic [3:0] func_i,
  input  logic       blk_i,
  output logic       par_set_o,
  output logic       par_clr_o,
  output logic       opnd_fn_o
);
  always_comb begin
    par_set_o = 1'b0;
    par_clr_o = 1'b0;
    opnd_fn_o = 1'b0;
    case (func_i)
      4'd1, 4'd4, 4'd6, 4'd12, 4'd13: begin
        par_set_o = 1'b1;
        opnd_fn_o = 1'b1;
      end
      4'd2:                par_set_o = 1'b0;
      4'd14:               par_set_o = !blk_i;
      4'd5, 4'd7, 4'd9:    par_clr_o = 1'b1;
      default: ;
    endcase
    if (func_i == 4'd2) opnd_fn_o = 1'b1;
  end

  // r4_: a function never both sets and clears pending
  always_comb begin
    p_set_clr_excl_r4: assert (!(par_set_o && par_clr_o));
  end
endmodule

// File: rtl/acs_mode_bank.sv
module acs_mode_bank
  import acs_pkg::*;
#(
  parameter int unsigned NUM_LVL = 4,
  parameter int unsigned LVL_W   = $clog2(NUM_LVL)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LVL_W-1:0]         lvl_i,
  input  logic                     wr_en_i,
  input  mode_t                    wr_mode_i,
  output mode_t                    cur_o,
  output mode_t [NUM_LVL-1:0]      all_o
);
  mode_t [NUM_LVL-1:0] bank_q;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   bank_q[g] <= '0;
      else if (wr_en_i && lvl_i == LVL_W'(g))        bank_q[g] <= wr_mode_i;
    end
  end

  assign cur_o = bank_q[lvl_i];
  assign all_o = bank_q;

  p_bank_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(bank_q));
endmodule

// File: rtl/acs_ptr.sv
module acs_ptr #(
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             clr_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  // natural wrap of the low bits keeps the window closed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '1;
    else if (clr_i) ptr_q <= '1;
    else if (up_i)  ptr_q <= ptr_q + 1'b1;
    else if (dn_i)  ptr_q <= ptr_q - 1'b1;
  end

  assign ptr_o = ptr_q;

  p_one_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_i && dn_i));
endmodule

// File: rtl/acs_xfer_seq.sv
module acs_xfer_seq
  import acs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ins_valid_i,
  input  logic   push_req_i,
  input  logic   pop_req_i,
  input  logic   two_word_i,
  input  logic   ack_i,
  output phase_e phase_o,
  output logic   idx_o,
  output logic   done_o
);
  phase_e phase_q, cur_ph;
  logic   idx_q, cur_idx, last_w, fin_ph;

  always_comb begin
    if (phase_q == PH_NONE) begin
      cur_ph  = push_req_i ? PH_PUSH : (pop_req_i ? PH_POP : PH_NONE);
      cur_idx = 1'b0;
    end else begin
      cur_ph  = phase_q;
      cur_idx = idx_q;
    end
  end

  assign last_w  = !two_word_i || cur_idx;
  assign fin_ph  = (cur_ph == PH_POP) || !pop_req_i;
  assign done_o  = ins_valid_i && ((cur_ph == PH_NONE) || (ack_i && last_w && fin_ph));
  assign phase_o = cur_ph;
  assign idx_o   = cur_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_NONE;
      idx_q   <= 1'b0;
    end else if (ack_i) begin
      if (!last_w) begin
        phase_q <= cur_ph;
        idx_q   <= 1'b1;
      end else if (cur_ph == PH_PUSH && pop_req_i) begin
        phase_q <= PH_POP;
        idx_q   <= 1'b0;
      end else begin
        phase_q <= PH_NONE;
        idx_q   <= 1'b0;
      end
    end
  end

  p_ack_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> cur_ph != PH_NONE);
endmodule

// File: rtl/acc_stack_ctrl.sv
module acc_stack_ctrl
  import acs_pkg::*;
#(
  parameter int unsigned NUM_LVL = 4,
  parameter int unsigned LVL_W   = $clog2(NUM_LVL),
  parameter int unsigned PTR_W   = 6,
  parameter int unsigned WORD_W  = 18,
  parameter int unsigned ADDR_W  = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  output logic              ins_ready_o,
  input  logic [3:0]        func_i,
  input  logic              modified_i,
  input  logic              addr_zero_i,
  input  logic              blk_xfer_i,
  input  logic [1:0]        sys_op_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] exp_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] pop_mant_o,
  output logic [WORD_W-1:0] pop_exp_o,
  output logic              extra_cycle_o,
  output logic [3:0]        mode_o,
  output logic [WORD_W-1:0] rdback_o
);
  localparam int unsigned PAD_W = WORD_W - 4 - ADDR_W;

  mode_t                cur, wr_mode;
  mode_t [NUM_LVL-1:0]  all_modes;
  phase_e               phase;
  logic                 idx, done, ack, wr_en;
  logic                 par_set, par_clr, opnd_fn;
  logic                 need_push, need_pop, is_sys, set_modes, ptr_rst;
  logic [PTR_W-1:0]     ptr;
  logic [WORD_W-1:0]    mant_q, exp_q;

  acs_par_rule u_rule (
    .func_i    (func_i),
    .blk_i     (blk_xfer_i),
    .par_set_o (par_set),
    .par_clr_o (par_clr),
    .opnd_fn_o (opnd_fn)
  );

  assign is_sys    = (func_i == 4'd15);
  assign set_modes = is_sys && (sys_op_i == OP_SET_MODES);
  assign ptr_rst   = is_sys && (sys_op_i == OP_PTR_RST);
  assign need_push = ins_valid_i && (func_i == 4'd4) && cur.stk && cur.par;
  assign need_pop  = ins_valid_i && cur.stk && !modified_i && addr_zero_i && opnd_fn;
  assign ack       = mem_req_valid_o && mem_req_ready_i;

  acs_xfer_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ins_valid_i (ins_valid_i),
    .push_req_i  (need_push),
    .pop_req_i   (need_pop),
    .two_word_i  (cur.flp),
    .ack_i       (ack),
    .phase_o     (phase),
    .idx_o       (idx),
    .done_o      (done)
  );

  acs_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .up_i   (ack && phase == PH_PUSH),
    .dn_i   (ack && phase == PH_POP),
    .clr_i  (done && ptr_rst),
    .ptr_o  (ptr)
  );

  always_comb begin
    if (set_modes) wr_mode = mode_t'(acc_i[WORD_W-1 -: 4]);
    else           wr_mode = '{flp: cur.flp, stk: cur.stk, par: par_set, ovf: cur.ovf};
  end
  assign wr_en = done && (set_modes || (cur.stk && (par_set || par_clr)));

  acs_mode_bank #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (level_i),
    .wr_en_i   (wr_en),
    .wr_mode_i (wr_mode),
    .cur_o     (cur),
    .all_o     (all_modes)
  );

  // push pre-increments, pop reads in place
  assign mem_req_valid_o = (phase != PH_NONE);
  assign mem_we_o        = (phase == PH_PUSH);
  assign mem_addr_o      = {1'b1, mem_we_o ? PTR_W'(ptr + 1'b1) : ptr};
  assign mem_wdata_o     = (cur.flp && !idx) ? exp_i : acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_q <= '0;
      exp_q  <= '0;
    end else if (ack && phase == PH_POP) begin
      if (!cur.flp || !idx) mant_q <= mem_rdata_i;
      else                  exp_q  <= mem_rdata_i;
    end
  end

  assign pop_mant_o    = mant_q;
  assign pop_exp_o     = exp_q;
  assign extra_cycle_o = need_push;
  assign ins_ready_o   = done;
  assign mode_o        = cur;
  assign rdback_o      = {cur, {PAD_W{1'b0}}, 1'b1, ptr};

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_no_req_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_valid_i |-> !mem_req_valid_o);

  p_ready_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_ready_o |-> ins_valid_i);

  p_push_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && mem_we_o) |=> ptr == $past(mem_addr_o[PTR_W-1:0]));

  p_pop_retracts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !mem_we_o) |=> ptr == PTR_W'($past(mem_addr_o[PTR_W-1:0]) - 1'b1));

  p_par_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && cur.stk && par_clr) |=> !all_modes[$past(level_i)].par);

  p_ptr_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && ptr_rst) |=> ptr == '1);
endmodule

// File: tb/acc_stack_ctrl_tb_top.sv
`timescale 1ns/1ps
module acc_stack_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [3:0]  func = '0;
  logic        modified = 1'b0, addr_zero = 1'b0, blk_xfer = 1'b0;
  logic [1:0]  sys_op = '0, level = '0;
  logic [17:0] acc = '0, expv = '0;
  logic        mreq, mrdy = 1'b1, mwe;
  logic [6:0]  maddr;
  logic [17:0] mwdata, mrdata, pop_mant, pop_exp, rdback;
  logic        extra;
  logic [3:0]  mode;

  logic [17:0] bmem [128];
  logic [17:0] mmem [128];
  logic [3:0]  m_mode [4];
  int          m_ptr;
  int          total = 0, fails = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  acc_stack_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ins_valid_i(ins_valid), .ins_ready_o(ins_ready),
    .func_i(func), .modified_i(modified), .addr_zero_i(addr_zero), .blk_xfer_i(blk_xfer),
    .sys_op_i(sys_op), .level_i(level), .acc_i(acc), .exp_i(expv),
    .mem_req_valid_o(mreq), .mem_req_ready_i(mrdy), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .pop_mant_o(pop_mant), .pop_exp_o(pop_exp),
    .extra_cycle_o(extra), .mode_o(mode), .rdback_o(rdback)
  );

  assign mrdata = bmem[maddr];
  always @(posedge clk) if (mreq && mrdy && mwe) bmem[maddr] <= mwdata;
  always @(negedge clk) mrdy <= ($urandom % 4) != 0;

  task automatic chk(input bit ok, input string req, input int act, input int expd);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
    end
  endtask

  function automatic logic [17:0] exp_rd(input int lv);
    return {m_mode[lv], 7'b0, 7'(m_ptr)};
  endfunction

  function automatic int up(input int p);
    return (p == 127) ? 64 : p + 1;
  endfunction

  function automatic int dn(input int p);
    return (p == 64) ? 127 : p - 1;
  endfunction

  task automatic exec(input int f, input bit md, input bit az, input int lv, input bit bk,
                      input int op, input logic [17:0] a, input logic [17:0] q);
    logic [3:0] cm;
    bit stk, flp, par, npush, npop, fset, fclr;
    int cyc;
    cm    = m_mode[lv];
    flp   = cm[3]; stk = cm[2]; par = cm[1];
    npush = (f == 4) && stk && par;
    npop  = stk && !md && az && (f inside {1, 2, 4, 6, 12, 13});
    fset  = (f inside {1, 4, 6, 12, 13}) || (f == 14 && !bk);
    fclr  = f inside {5, 7, 9};
    @(negedge clk);
    func = 4'(f); modified = md; addr_zero = az; level = 2'(lv); blk_xfer = bk;
    sys_op = 2'(op); acc = a; expv = q; ins_valid = 1'b1;
    #1;
    chk(extra == npush, "R5 extra_cycle", int'(extra), int'(npush));
    cyc = 0;
    while (!ins_ready) begin
      @(negedge clk); #1;
      cyc++;
      if (cyc > 200) begin
        chk(1'b0, "R10 instruction hung", 0, 1);
        break;
      end
    end
    @(posedge clk); #1;
    ins_valid = 1'b0;
    if (npush) begin
      if (flp) begin
        m_ptr = up(m_ptr); mmem[m_ptr] = q;
        chk(bmem[m_ptr] == q, "R7 push exponent", int'(bmem[m_ptr]), int'(q));
        m_ptr = up(m_ptr); mmem[m_ptr] = a;
        chk(bmem[m_ptr] == a, "R7 push mantissa", int'(bmem[m_ptr]), int'(a));
      end else begin
        m_ptr = up(m_ptr); mmem[m_ptr] = a;
        chk(bmem[m_ptr] == a, "R5 push word", int'(bmem[m_ptr]), int'(a));
      end
    end
    if (npop) begin
      chk(pop_mant == mmem[m_ptr], "R6 pop operand", int'(pop_mant), int'(mmem[m_ptr]));
      m_ptr = dn(m_ptr);
      if (flp) begin
        chk(pop_exp == mmem[m_ptr], "R7 pop exponent", int'(pop_exp), int'(mmem[m_ptr]));
        m_ptr = dn(m_ptr);
      end
    end
    if (stk && fset) cm[1] = 1'b1;
    if (stk && fclr) cm[1] = 1'b0;
    if (f == 15 && op == 2) cm = a[17:14];
    if (f == 15 && op == 1) m_ptr = 127;
    m_mode[lv] = cm;
    chk(rdback == exp_rd(lv), "R2/R4 readback", int'(rdback), int'(exp_rd(lv)));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL R10 watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) begin
      bmem[i] = 18'(i * 37 + 5);
      mmem[i] = 18'(i * 37 + 5);
    end
    for (int i = 0; i < 4; i++) m_mode[i] = '0;
    m_ptr = 127;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(rdback == 18'h0007F, "R1 reset readback", int'(rdback), 'h7F);
    chk(!mreq, "R10 no request idle", int'(mreq), 0);

    // R2 set flags on level 0: stacking only
    exec(15, 0, 0, 0, 0, 2, 18'h10000, 0);
    chk(mode == 4'b0100, "R2 mode_o", int'(mode), 4);
    // R3 level 2 write leaves level 0 untouched
    exec(15, 0, 0, 2, 0, 2, 18'h3C000, 0);
    exec(8, 0, 0, 0, 0, 0, 0, 0);
    chk(rdback[17:14] == 4'b0100, "R3 level 0 unchanged", int'(rdback[17:14]), 4);
    // R4 add sets pending, store clears, jump keeps
    exec(1, 1, 0, 0, 0, 0, 18'h111, 0);
    exec(8, 0, 0, 0, 0, 0, 0, 0);
    chk(rdback[15] == 1'b1, "R4 pending kept by function 8", int'(rdback[15]), 1);
    exec(5, 0, 0, 0, 0, 0, 0, 0);
    exec(1, 1, 0, 0, 0, 0, 0, 0);
    // R5 lazy push from 127 wraps to 64 (R8)
    exec(4, 1, 0, 0, 0, 0, 18'h2ABCD, 0);
    chk(rdback[6:0] == 7'd64, "R8 push wrap", int'(rdback[6:0]), 64);
    // R6 pop at 64 wraps to 127 (R8)
    exec(1, 0, 1, 0, 0, 0, 0, 0);
    chk(pop_mant == 18'h2ABCD, "R6 pop value", int'(pop_mant), 'h2ABCD);
    chk(rdback[6:0] == 7'd127, "R8 pop wrap", int'(rdback[6:0]), 127);
    // R6 modified: no pop
    exec(1, 1, 1, 0, 0, 0, 0, 0);
    chk(rdback[6:0] == 7'd127, "R6 modified no pop", int'(rdback[6:0]), 127);
    // R7 floating push and pop on level 1
    exec(15, 0, 0, 1, 0, 2, 18'h38000, 0);
    exec(4, 1, 0, 1, 0, 0, 18'h01234, 18'h00055);
    exec(2, 0, 1, 1, 0, 0, 0, 0);
    chk(pop_mant == 18'h01234 && pop_exp == 18'h00055, "R7 pop pair",
        int'(pop_mant), 'h1234);
    // R9 pointer reset after a push
    exec(4, 1, 0, 1, 0, 0, 18'h777, 18'h9);
    exec(15, 0, 0, 1, 0, 1, 0, 0);
    chk(rdback[6:0] == 7'd127, "R9 pointer reset", int'(rdback[6:0]), 127);
    // R4 stacking clear: pending never moves
    exec(15, 0, 0, 3, 0, 2, 18'h08000, 0);
    exec(5, 0, 0, 3, 0, 0, 0, 0);
    chk(rdback[15] == 1'b1, "R4 no change when stacking clear", int'(rdback[15]), 1);

    // random mix
    for (int n = 0; n < 700; n++) begin
      int f, lv, op;
      lv = int'($urandom % 4);
      f  = int'($urandom % 16);
      op = 0;
      if (($urandom % 10) == 0) begin
        f = 15; op = 2;
      end else if (($urandom % 40) == 0) begin
        f = 15; op = 1;
      end
      exec(f, 1'($urandom % 3 == 0), 1'($urandom % 2), lv, 1'($urandom % 2), op,
           18'($urandom), 18'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule